// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block holds bytes that a serial receiver has already deserialised until a host reads them. In FIFO mode it queues up to sixteen bytes in arrival order. It reports a programmable trigger level, a data-ready flag, a break flag, an overrun flag and a fill count. A character-timeout detector raises a pending flag when data has been left unread for four character times. In the other mode a single holding register stands in for the queue, and each new byte replaces the previous one.

The host controls the block with a byte-wide control write. It reads queued data through a data-read strobe. It clears the sticky error flags through a line-status read strobe. The length of one character is supplied as a count of clock cycles, so the timeout follows whatever line rate the receiver uses. A received break is treated as a zero byte that also raises the break flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: In FIFO mode, bytes are returned in arrival order. `count_o` gives the number of stored bytes, from 0 to 16. A push and a read in the same cycle leave the count unchanged.
- R2: Control bits 7:6 select the trigger level shown on `trig_level_o`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The reset value is 1.
- R3: In FIFO mode, a byte that arrives while 16 bytes are stored and no read is made is dropped, the stored bytes are kept, and `overrun_o` is set. A push together with a read on a full FIFO is accepted and does not set overrun.
- R4: In FIFO mode, `rd_data_o` shows the oldest byte, or 0x00 when the FIFO is empty. Data-ready is high exactly while bytes are stored, so it clears when a read empties the FIFO.
- R5: A break event pushes a 0x00 byte and sets both `break_o` and `data_ready_o`. In FIFO mode the break flag clears when a read empties the FIFO.
- R6: A line-status read clears `break_o` and `overrun_o`. A new event in the same cycle takes precedence over the clear.
- R7: In FIFO mode, every push, and every read that leaves data behind, restarts a timer of 4 x `char_cycles_i` clock cycles. If the timer runs out with data still stored, `timeout_o` rises exactly that many cycles after the restarting edge. Any data read clears `timeout_o`.
- R8: A control write with bit 1 set empties the FIFO and clears data-ready, break and timeout. During a control-write cycle, received bytes and reads are ignored.
- R9: Control bit 0 enables FIFO mode. A control write that changes this bit also performs the bit-1 flush, even when bit 1 is clear.
- R10: With FIFO mode off, a received byte goes into a single holding register shown on `rd_data_o` and sets data-ready. A byte that arrives while data-ready is set, without a read in the same cycle, overwrites the register and sets overrun. A read clears data-ready.
- R11: After reset, FIFO mode is off, the count is 0, and data-ready, break, overrun and timeout are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_break_i | input | 1 | Break event strobe (pushes 0x00) |
| data_rd_i | input | 1 | Host read of receive data |
| lsr_rd_i | input | 1 | Host read of line status |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 8 | Control value: bit 0 enable, bit 1 flush, bits 7:6 trigger |
| char_cycles_i | input | 16 | Clock cycles in one character time |
| rd_data_o | output | 8 | Byte returned to a data read |
| data_ready_o | output | 1 | Data available |
| break_o | output | 1 | Break received |
| overrun_o | output | 1 | Byte lost |
| count_o | output | 5 | Bytes stored |
| trig_level_o | output | 5 | Trigger level in bytes |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The hardest case to reach from the ports is a timeout expiring after the timer has been restarted by a read that leaves data behind. The bench sets a short character time and keeps two bytes queued. It reads one byte partway through the window, then counts clock edges from that read and checks that the flag is still low one cycle before the new expiry and high on the expiry itself. A full FIFO with a push and a read in the same cycle is reached by filling sixteen bytes and clearing the overrun through a status read first. The bench then drains the FIFO to show that the byte accepted that way landed at the tail.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int TRIG_W = 5;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic logic [TRIG_W-1:0] trig_bytes(trig_sel_e s);
    case (s)
      TRIG_1:  return TRIG_W'(1);
      TRIG_4:  return TRIG_W'(4);
      TRIG_8:  return TRIG_W'(8);
      default: return TRIG_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [W-1:0]               wdata_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [NW-1:0] FULL_N = NW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // storage carries no reset; the count guards every read
  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == FULL_N);
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rxq_timer.sv
`timescale 1ns/1ps
module rxq_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cancel_i,
  input  logic          restart_i,
  input  logic          clear_i,
  input  logic          have_data_i,
  input  logic [CW-1:0] char_cycles_i,
  output logic          pend_o
);
  localparam int TW = CW + 2;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;
  logic          armed_q, pend_q;
  logic [TW-1:0] limit;

  assign limit = {char_cycles_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (cancel_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (restart_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q + ONE >= limit) begin
          armed_q <= 1'b0;
          if (have_data_i) pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
      if (clear_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                rx_byte_i,
  input  logic                      rx_valid_i,
  input  logic                      rx_break_i,
  input  logic                      data_rd_i,
  input  logic                      lsr_rd_i,
  input  logic                      ctl_wr_i,
  input  logic [7:0]                ctl_data_i,
  input  logic [CW-1:0]             char_cycles_i,
  output logic [7:0]                rd_data_o,
  output logic                      data_ready_o,
  output logic                      break_o,
  output logic                      overrun_o,
  output logic [$clog2(DEPTH):0]    count_o,
  output logic [rxq_pkg::TRIG_W-1:0] trig_level_o,
  output logic                      timeout_o
);
  import rxq_pkg::*;
  localparam int NW = $clog2(DEPTH) + 1;
  localparam logic [NW-1:0] ONE_N = NW'(1);

  logic            fifo_en_q, dr_q, brk_q, ovr_q;
  trig_sel_e       trig_q;
  logic [7:0]      hold_q;
  logic            dr_d, brk_d, ovr_d;

  logic            act, ctl_flush, rx_evt;
  logic [7:0]      rx_val;
  logic            push, pop, push_ok, drop, last_pop;
  logic [7:0]      head;
  logic [NW-1:0]   cnt;
  logic            full, empty;
  logic            unused_ctl;

  assign unused_ctl = ^ctl_data_i[5:2];

  assign act       = !ctl_wr_i;
  assign ctl_flush = ctl_wr_i && (ctl_data_i[1] || (ctl_data_i[0] != fifo_en_q));
  assign rx_evt    = act && (rx_valid_i || rx_break_i);
  assign rx_val    = rx_break_i ? 8'h00 : rx_byte_i;

  assign push     = fifo_en_q && rx_evt;
  assign pop      = fifo_en_q && act && data_rd_i && !empty;
  assign push_ok  = push && (!full || pop);
  assign drop     = push && full && !pop;
  assign last_pop = pop && (cnt == ONE_N) && !push;

  rxq_store #(.DEPTH(DEPTH), .W(8)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctl_flush),
    .push_i  (push_ok),
    .pop_i   (pop),
    .wdata_i (rx_val),
    .rdata_o (head),
    .count_o (cnt),
    .full_o  (full),
    .empty_o (empty)
  );

  rxq_timer #(.CW(CW)) i_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cancel_i      (ctl_flush || last_pop),
    .restart_i     (push || (pop && cnt > ONE_N)),
    .clear_i       (fifo_en_q && act && data_rd_i),
    .have_data_i   (!empty),
    .char_cycles_i (char_cycles_i),
    .pend_o        (timeout_o)
  );

  // flag next-state: clears first, new events override
  always_comb begin
    dr_d  = dr_q;
    brk_d = brk_q;
    ovr_d = ovr_q;
    if (ctl_flush) begin
      dr_d  = 1'b0;
      brk_d = 1'b0;
    end else if (act) begin
      if (lsr_rd_i) begin
        brk_d = 1'b0;
        ovr_d = 1'b0;
      end
      if (fifo_en_q) begin
        if (last_pop) begin
          dr_d  = 1'b0;
          brk_d = 1'b0;
        end
        if (push) dr_d = 1'b1;
        if (drop) ovr_d = 1'b1;
      end else begin
        if (data_rd_i && !rx_evt) begin
          dr_d  = 1'b0;
          brk_d = 1'b0;
        end
        if (rx_evt) begin
          dr_d = 1'b1;
          if (dr_q && !data_rd_i) ovr_d = 1'b1;
        end
      end
      if (rx_evt && rx_break_i) brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      trig_q    <= TRIG_1;
      hold_q    <= 8'h00;
      dr_q      <= 1'b0;
      brk_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (ctl_wr_i) begin
        fifo_en_q <= ctl_data_i[0];
        trig_q    <= trig_sel_e'(ctl_data_i[7:6]);
      end
      if (!fifo_en_q && rx_evt) hold_q <= rx_val;
      dr_q  <= dr_d;
      brk_q <= brk_d;
      ovr_q <= ovr_d;
    end
  end

  assign rd_data_o    = fifo_en_q ? (empty ? 8'h00 : head) : hold_q;
  assign data_ready_o = dr_q;
  assign break_o      = brk_q;
  assign overrun_o    = ovr_q;
  assign count_o      = cnt;
  assign trig_level_o = trig_bytes(trig_q);
endmodule

// File: rtl/uart_rx_fifo_chk.sv
`timescale 1ns/1ps
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       rx_valid_i,
  input logic                       rx_break_i,
  input logic                       data_rd_i,
  input logic                       lsr_rd_i,
  input logic                       ctl_wr_i,
  input logic [7:0]                 ctl_data_i,
  input logic [7:0]                 rd_data_o,
  input logic                       data_ready_o,
  input logic                       break_o,
  input logic                       overrun_o,
  input logic [$clog2(DEPTH):0]     count_o,
  input logic [rxq_pkg::TRIG_W-1:0] trig_level_o,
  input logic                       timeout_o,
  input logic                       fifo_en_q
);
  localparam int NW = $clog2(DEPTH) + 1;
  localparam logic [NW-1:0] FULL_N = NW'(DEPTH);
  localparam logic [rxq_pkg::TRIG_W-1:0] T14 = rxq_pkg::TRIG_W'(14);

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_N);

  p_trig_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_data_i[7:6] == 2'b11 |=> trig_level_o == T14);

  p_overrun_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i && fifo_en_q && count_o == FULL_N && (rx_valid_i || rx_break_i) && !data_rd_i
    |=> overrun_o && count_o == FULL_N);

  p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_q && count_o == '0 |-> rd_data_o == 8'h00);

  p_ready_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_q |-> data_ready_o == (count_o != '0));

  p_lsr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !ctl_wr_i && !rx_valid_i && !rx_break_i |=> !overrun_o && !break_o);

  p_timeout_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> count_o != '0);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !ctl_wr_i |=> !timeout_o);

  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_data_i[1] |=> count_o == '0 && !data_ready_o && !break_o && !timeout_o);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_break_i   (rx_break_i),
  .data_rd_i    (data_rd_i),
  .lsr_rd_i     (lsr_rd_i),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_data_i   (ctl_data_i),
  .rd_data_o    (rd_data_o),
  .data_ready_o (data_ready_o),
  .break_o      (break_o),
  .overrun_o    (overrun_o),
  .count_o      (count_o),
  .trig_level_o (trig_level_o),
  .timeout_o    (timeout_o),
  .fifo_en_q    (fifo_en_q)
);

// File: tb/test_uart_rx_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, data_rd = 1'b0, lsr_rd = 1'b0, ctl_wr = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic [15:0] char_cycles = 16'd1000;
  logic [7:0]  rd_data;
  logic        dr, brk, ovr, tmo;
  logic [4:0]  cnt, trig;
  logic [7:0]  last_rd;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo i_uart_rx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .rx_break_i(rx_break), .data_rd_i(data_rd), .lsr_rd_i(lsr_rd), .ctl_wr_i(ctl_wr),
    .ctl_data_i(ctl_data), .char_cycles_i(char_cycles), .rd_data_o(rd_data),
    .data_ready_o(dr), .break_o(brk), .overrun_o(ovr), .count_o(cnt),
    .trig_level_o(trig), .timeout_o(tmo)
  );

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [7:0] din;
    logic [7:0] exp_rd;
    logic [4:0] exp_cnt;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b0, 8'hA1, 8'h00, 5'd1},
    '{1'b1, 1'b0, 8'hA2, 8'h00, 5'd2},
    '{1'b1, 1'b0, 8'hA3, 8'h00, 5'd3},
    '{1'b0, 1'b1, 8'h00, 8'hA1, 5'd2},
    '{1'b1, 1'b1, 8'hA4, 8'hA2, 5'd2},
    '{1'b0, 1'b1, 8'h00, 8'hA3, 5'd1},
    '{1'b0, 1'b1, 8'h00, 8'hA4, 5'd0},
    '{1'b0, 1'b1, 8'h00, 8'h00, 5'd0},
    '{1'b1, 1'b0, 8'h5C, 8'h00, 5'd1},
    '{1'b0, 1'b1, 8'h00, 8'h5C, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one bus cycle: drive at negedge, capture read data before the edge, release after it
  task automatic cyc(input logic p, input logic b, input logic r, input logic l, input logic [7:0] d);
    @(negedge clk);
    rx_valid = p; rx_break = b; data_rd = r; lsr_rd = l; rx_byte = d;
    #1 last_rd = rd_data;
    @(posedge clk); #1;
    rx_valid = 0; rx_break = 0; data_rd = 0; lsr_rd = 0; rx_byte = '0;
  endtask

  task automatic ctl(input logic [7:0] v, input logic with_rx);
    @(negedge clk);
    ctl_wr = 1; ctl_data = v; rx_valid = with_rx; rx_byte = 8'h99; data_rd = with_rx;
    @(posedge clk); #1;
    ctl_wr = 0; rx_valid = 0; data_rd = 0; rx_byte = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11 reset state
    chk_eq("R11 count", cnt, 0);
    chk_eq("R11 flags", {dr, brk, ovr, tmo}, 0);
    chk_eq("R11 trigger", trig, 1);

    // R10 holding register mode
    cyc(1, 0, 0, 0, 8'h11);
    chk_eq("R10 ready", dr, 1);
    chk_eq("R10 data", rd_data, 8'h11);
    cyc(1, 0, 0, 0, 8'h22);
    chk_eq("R10 overrun", ovr, 1);
    chk_eq("R10 overwrite", rd_data, 8'h22);
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R10 read clears ready", dr, 0);
    cyc(0, 0, 0, 1, 8'h00);
    chk_eq("R6 status read clears overrun", ovr, 0);

    // R9 enable change forces flush
    cyc(1, 0, 0, 0, 8'h33);
    ctl(8'h01, 0);
    chk_eq("R9 flush on enable", {dr, cnt}, 0);

    // R1 R4 vector table
    foreach (VEC[i]) begin
      cyc(VEC[i].push, 0, VEC[i].pop, 0, VEC[i].din);
      if (VEC[i].pop) chk_eq($sformatf("R1 R4 vec%0d data", i), last_rd, VEC[i].exp_rd);
      chk_eq($sformatf("R1 vec%0d count", i), cnt, VEC[i].exp_cnt);
      chk_eq($sformatf("R4 vec%0d ready", i), dr, (VEC[i].exp_cnt != 0));
    end

    // R2 trigger levels
    ctl(8'h41, 0); chk_eq("R2 level 01", trig, 4);
    ctl(8'h81, 0); chk_eq("R2 level 10", trig, 8);
    ctl(8'hC1, 0); chk_eq("R2 level 11", trig, 14);
    ctl(8'h01, 0); chk_eq("R2 level 00", trig, 1);

    // R3 overrun on full FIFO
    for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 8'(i + 1));
    chk_eq("R3 full count", cnt, 16);
    cyc(1, 0, 0, 0, 8'hEE);
    chk_eq("R3 overrun set", ovr, 1);
    chk_eq("R3 count kept", cnt, 16);
    cyc(0, 0, 0, 1, 8'h00);
    chk_eq("R6 overrun cleared", ovr, 0);
    cyc(1, 0, 1, 0, 8'h77);
    chk_eq("R3 push+pop data", last_rd, 8'h01);
    chk_eq("R3 push+pop no overrun", ovr, 0);
    chk_eq("R3 push+pop count", cnt, 16);
    for (int i = 0; i < 15; i++) begin
      cyc(0, 0, 1, 0, 8'h00);
      chk_eq("R3 drain order", last_rd, i + 2);
    end
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R3 tail byte", last_rd, 8'h77);
    chk_eq("R3 drained", cnt, 0);

    // R5 break insertion
    cyc(0, 1, 0, 0, 8'h00);
    chk_eq("R5 break push", {brk, dr, cnt}, {1'b1, 1'b1, 5'd1});
    cyc(0, 0, 0, 1, 8'h00);
    chk_eq("R6 break cleared, ready kept", {brk, dr}, 2'b01);
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R5 zero byte", last_rd, 0);
    chk_eq("R5 break held while data left", {brk, cnt}, {1'b1, 5'd1});
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R5 break cleared on empty", {brk, dr, cnt}, 0);

    // R7 character timeout, 4 x 10 cycles
    char_cycles = 16'd10;
    cyc(1, 0, 0, 0, 8'h61);
    repeat (39) @(posedge clk);
    #1 chk_eq("R7 not yet", tmo, 0);
    @(posedge clk); #1 chk_eq("R7 expires", tmo, 1);
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R7 read clears", tmo, 0);
    chk_eq("R4 read empties", {dr, cnt}, 0);
    cyc(1, 0, 0, 0, 8'h62);
    cyc(1, 0, 0, 0, 8'h63);
    repeat (20) @(posedge clk);
    #1;
    cyc(0, 0, 1, 0, 8'h00);
    chk_eq("R7 restart read data", last_rd, 8'h62);
    repeat (39) @(posedge clk);
    #1 chk_eq("R7 restarted not yet", tmo, 0);
    @(posedge clk); #1 chk_eq("R7 restarted expires", tmo, 1);

    // R8 flush with a receive in the same cycle
    cyc(1, 0, 0, 0, 8'h71);
    ctl(8'h03, 1);
    chk_eq("R8 flush clears", {cnt, dr, brk, tmo}, 0);
    @(posedge clk); #1;
    chk_eq("R8 rx ignored in ctl cycle", cnt, 0);

    done = 1;
    finish_run();
  end
endmodule